// File: doc/BRIEF.md
# ROM-to-Register-Bank Sequential Loader

This block copies the contents of a small constant table, read through a registered (one-cycle-latency) ROM port, into a bank of output registers. After the load, register k holds table word k. An address counter walks the table from the first entry to the last and then stops. The word that comes out of the ROM goes to exactly one register. That register is selected by the address from the previous cycle, which travels alongside the read data. A sticky flag reports that the last register has been filled.

A single count-enable input gates the whole machine: the counter, the address/data pipeline stage and the register writes. While the enable is held low, the load pauses. When the enable returns, the load resumes where it stopped. A synchronous reset clears everything so the load can be started again.

Top module: `rom_bank_loader`

## Requirements
- R1: While reset is high at a clock edge, every bank register becomes zero and the done flag becomes low after that edge.
- R2: The counter presents the addresses 0 to DEPTH-1 in ascending order, once each. After the last address it holds instead of wrapping, and later enabled cycles leave the bank and the done flag unchanged.
- R3: The table word at address k is 0x0AD4 for k=0, 0x0087 for k=1 and 0xAF41 for k=2. For k of 3 or more it is (k*0x1357 + 0x2468) truncated to DATA_W bits. Bank entry k (bits k*DATA_W and up of `bank_o`) ends up holding word k.
- R4: Each word read from the ROM is written into exactly one bank entry, chosen by the address delayed by one enabled cycle. All other entries keep their value.
- R5: A clock edge with the enable low changes neither the bank, the done flag, the address nor the pipeline stage.
- R6: The done flag rises at the same edge that makes entry DEPTH-1 visible, which is the (DEPTH+1)-th enabled edge after reset. It then stays high until reset.
- R7: For any pattern of enable pauses, entry k shows word k exactly from the (k+2)-th enabled edge after reset onward. No entry is skipped or written twice.
- R8: An entry that has not been written yet reads zero. The first enabled edge after reset writes no entry.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| en | input | 1 | Count enable shared by counter, pipeline and bank |
| bank_o | output | DEPTH*DATA_W | Bank registers, entry k at bits [k*DATA_W +: DATA_W] |
| done_o | output | 1 | High once the final entry has been loaded |

## Verification
The assertions assume that reset is high at the first clock edge. They also assume that `en` and `rst` are free of X at every edge, because the pairing of write index and data relies on the enable being known whenever the stage might advance. The bench holds reset through the opening cycle. It changes both inputs only at falling edges and always drives them to defined values, whether the enable runs continuously, alternates, or follows a pseudo-random pause pattern.

// File: rtl/rom_loader_pkg.sv
package rom_loader_pkg;

    // Constant table content, computed rather than loaded.
    function automatic logic [31:0] rom_word(input int unsigned k);
        case (k)
            0:       rom_word = 32'h0000_0AD4;
            1:       rom_word = 32'h0000_0087;
            2:       rom_word = 32'h0000_AF41;
            default: rom_word = k * 32'h1357 + 32'h2468;
        endcase
    endfunction

endpackage

// File: rtl/loader_addr_ctr.sv
module loader_addr_ctr #(
    parameter int DEPTH  = 10,
    parameter int ADDR_W = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              en,
    output logic [ADDR_W-1:0] addr_o,
    output logic              issue_o
);
    localparam logic [ADDR_W-1:0] LAST = ADDR_W'(DEPTH - 1);

    typedef struct packed {
        logic [ADDR_W-1:0] addr;
        logic              spent;
    } ctr_t;

    ctr_t ctr_d, ctr_q;

    always_comb begin
        ctr_d = ctr_q;
        if (en && !ctr_q.spent) begin
            if (ctr_q.addr == LAST) ctr_d.spent = 1'b1;
            else                    ctr_d.addr  = ctr_q.addr + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) ctr_q <= '0;
        else     ctr_q <= ctr_d;
    end

    assign addr_o  = ctr_q.addr;
    assign issue_o = en && !ctr_q.spent;

    p_addr_in_range_r2: assert property (@(posedge clk) disable iff (rst)
        addr_o <= LAST);
    p_hold_at_end_r2: assert property (@(posedge clk) disable iff (rst)
        (ctr_q.spent && addr_o == LAST) |=> (addr_o == LAST));
    p_addr_frozen_r5: assert property (@(posedge clk) disable iff (rst)
        !en |=> $stable(addr_o));
endmodule

// File: rtl/loader_rom_stage.sv
module loader_rom_stage
    import rom_loader_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int ADDR_W = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              en,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic              issue_i,
    output logic [DATA_W-1:0] data_o,
    output logic [ADDR_W-1:0] widx_o,
    output logic              wval_o
);
    typedef struct packed {
        logic [DATA_W-1:0] data;
        logic [ADDR_W-1:0] widx;
        logic              wval;
    } stage_t;

    stage_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (en) begin
            st_d.data = DATA_W'(rom_word(int'(addr_i)));
            st_d.widx = addr_i;
            st_d.wval = issue_i;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    assign data_o = st_q.data;
    assign widx_o = st_q.widx;
    assign wval_o = st_q.wval;

    p_no_write_after_reset_r8: assert property (@(posedge clk)
        rst |=> !wval_o);
    p_stage_frozen_r5: assert property (@(posedge clk) disable iff (rst)
        !en |=> ($stable(widx_o) && $stable(wval_o) && $stable(data_o)));
endmodule

// File: rtl/loader_reg_bank.sv
module loader_reg_bank #(
    parameter int DATA_W = 16,
    parameter int DEPTH  = 10,
    parameter int ADDR_W = 4
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic                         en,
    input  logic                         wval_i,
    input  logic [ADDR_W-1:0]            widx_i,
    input  logic [DATA_W-1:0]            data_i,
    output logic [DEPTH-1:0][DATA_W-1:0] bank_o,
    output logic                         done_o
);
    localparam logic [ADDR_W-1:0] LAST = ADDR_W'(DEPTH - 1);

    typedef struct packed {
        logic [DEPTH-1:0][DATA_W-1:0] bank;
        logic                         done;
    } bank_t;

    bank_t bk_d, bk_q;
    logic  wr_go;

    assign wr_go = en && wval_i;

    always_comb begin
        bk_d = bk_q;
        for (int k = 0; k < DEPTH; k++) begin
            if (wr_go && widx_i == ADDR_W'(k)) bk_d.bank[k] = data_i;
        end
        if (wr_go && widx_i == LAST) bk_d.done = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst) bk_q <= '0;
        else     bk_q <= bk_d;
    end

    assign bank_o = bk_q.bank;
    assign done_o = bk_q.done;

    p_done_sticky_r6: assert property (@(posedge clk) disable iff (rst)
        done_o |=> done_o);
    p_bank_frozen_r5: assert property (@(posedge clk) disable iff (rst)
        !en |=> ($stable(bank_o) && $stable(done_o)));
endmodule

// File: rtl/rom_bank_loader.sv
module rom_bank_loader
    import rom_loader_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int DEPTH  = 10
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic                         en,
    output logic [DEPTH-1:0][DATA_W-1:0] bank_o,
    output logic                         done_o
);
    localparam int ADDR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    logic [ADDR_W-1:0] addr_q;
    logic              issue;
    logic [DATA_W-1:0] rd_data_q;
    logic [ADDR_W-1:0] widx_q;
    logic              wval_q;

    loader_addr_ctr #(.DEPTH(DEPTH), .ADDR_W(ADDR_W)) i_ctr (
        .clk(clk), .rst(rst), .en(en), .addr_o(addr_q), .issue_o(issue)
    );

    loader_rom_stage #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) i_rom (
        .clk(clk), .rst(rst), .en(en), .addr_i(addr_q), .issue_i(issue),
        .data_o(rd_data_q), .widx_o(widx_q), .wval_o(wval_q)
    );

    loader_reg_bank #(.DATA_W(DATA_W), .DEPTH(DEPTH), .ADDR_W(ADDR_W)) i_bank (
        .clk(clk), .rst(rst), .en(en), .wval_i(wval_q), .widx_i(widx_q),
        .data_i(rd_data_q), .bank_o(bank_o), .done_o(done_o)
    );

    // The entry picked by the delayed index must hold the table word for that index.
    p_entry_matches_table_r3: assert property (@(posedge clk) disable iff (rst)
        (en && wval_q) |=> (bank_o[$past(widx_q)] == DATA_W'(rom_word(int'($past(widx_q))))));
    p_reset_clears_r1: assert property (@(posedge clk)
        rst |=> (bank_o == '0 && !done_o));
endmodule

// File: tb/test_rom_bank_loader.sv
module test_rom_bank_loader;
    localparam int DATA_W = 16;
    localparam int DEPTH  = 10;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic en  = 1'b0;
    logic [DEPTH-1:0][DATA_W-1:0] bank_o;
    logic done_o;

    int checks = 0;
    int errors = 0;
    int n_en   = 0;
    int cycles = 0;

    always #4 clk = ~clk;

    rom_bank_loader #(.DATA_W(DATA_W), .DEPTH(DEPTH)) i_rom_bank_loader (
        .clk(clk), .rst(rst), .en(en), .bank_o(bank_o), .done_o(done_o)
    );

    function automatic logic [DATA_W-1:0] exp_word(input int k);
        int unsigned v;
        if (k == 0)      v = 32'h0AD4;
        else if (k == 1) v = 32'h0087;
        else if (k == 2) v = 32'hAF41;
        else             v = k * 4951 + 9320;
        return DATA_W'(v);
    endfunction

    task automatic check_all(input string tag);
        for (int k = 0; k < DEPTH; k++) begin
            logic [DATA_W-1:0] e;
            string t;
            e = (n_en >= k + 2) ? exp_word(k) : '0;
            t = (n_en >= k + 2) ? tag : "R8";
            checks++;
            if (bank_o[k] !== e) begin
                errors++;
                $display("FAIL %s entry %0d after %0d enabled edges: got %h expected %h",
                         t, k, n_en, bank_o[k], e);
            end
        end
        checks++;
        if (done_o !== (n_en >= DEPTH + 1)) begin
            errors++;
            $display("FAIL R6 done after %0d enabled edges: got %b expected %b",
                     n_en, done_o, (n_en >= DEPTH + 1));
        end
    endtask

    task automatic step(input logic e, input string tag);
        en = e;
        @(posedge clk);
        if (e) n_en++;
        @(negedge clk);
        check_all(tag);
    endtask

    task automatic do_reset();
        rst = 1'b1;
        en  = 1'b1;
        @(posedge clk);
        @(negedge clk);
        n_en = 0;
        rst  = 1'b0;
        check_all("R1");
    endtask

    initial begin
        forever begin
            @(posedge clk);
            cycles++;
            if (cycles > 100000) begin
                errors++;
                $display("FAIL watchdog expired");
                $display("Simulation finished: %0d checks, %0d errors", checks, errors);
                $finish;
            end
        end
    end

    initial begin
        logic [7:0] lfsr;
        @(negedge clk);
        do_reset();
        // first enabled edges: single-entry writes, nothing on the first
        for (int i = 0; i < 4; i++) step(1'b1, "R4");
        for (int i = 0; i < 10; i++) step(1'b1, "R3");
        // holding after the final address
        for (int i = 0; i < 6; i++) step(1'b1, "R2");
        // reset in the middle of a load
        do_reset();
        for (int i = 0; i < 5; i++) step(1'b1, "R3");
        do_reset();
        // alternating enable with long pauses
        for (int i = 0; i < 30; i++) begin
            step(1'b1, "R7");
            step(1'b0, "R5");
            step(1'b0, "R5");
        end
        do_reset();
        lfsr = 8'hA5;
        for (int i = 0; i < 80; i++) begin
            lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
            step(lfsr[0], lfsr[0] ? "R7" : "R5");
        end
        for (int i = 0; i < 12; i++) step(1'b1, "R7");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule